// File: doc/BRIEF.md
# Up-Counting Timer with Fractional Period Correction

This block is a register-programmed timer whose count register climbs by one on each counting tick. It rolls over after the all-ones value, raises an overflow flag, and either starts again from a programmed reload value or wraps to zero. A counting tick is the functional tick-enable input, gated by a run bit. It can also be divided first by a power-of-two prescaler selected with a 3-bit field. An interrupt line is raised while the overflow flag and its enable bit are both set.

The block also holds a period-correction unit so that a slow reference can give a fractional average period. Take a 32768 Hz reference and a 1 ms target. The reload value gives a 32-tick base period. A signed accumulator, driven by a positive step and a negative step, then picks which periods are lengthened by one tick. With steps of 232000 and -768000, on average 768 periods out of every 1000 last 33 ticks, and the mean period comes out at 32.768 ticks.

Software reaches the block over a simple synchronous register bus. Writes take effect at the clock edge. Read data is combinational from the address. Register word addresses are: 0 control, 1 flags, 2 interrupt enable, 3 count, 4 reload, 5 trigger, 6 positive step, 7 negative step.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads zero and the interrupt output is low.
- R2: While control bit 0 (run) is clear, the count holds its value, whatever tick_en does.
- R3: When control bit 2 (prescale enable) is clear, each tick_en cycle with run set is one counting tick. When it is set, one counting tick happens every 2^(S+1) tick_en cycles, where S is control bits 5:3. Any write to the control register restarts the prescaler from zero.
- R4: A counting tick at count 0xFFFFFFFF is an overflow. The next count is the reload value if control bit 1 (auto-reload) is set, and zero otherwise.
- R5: A write to the count register sets the count to the written data. A write of any data to the trigger register copies the reload value into the count. A bus write takes priority over counting in the same cycle.
- R6: An overflow sets flags bit 1. Writing 1 to flags bit 1 clears it. Writes to other flag bits, or writes of 0, leave it unchanged. Flag bits 0 and 2 always read 0.
- R7: The irq output is high exactly while flags bit 1 and interrupt-enable bit 1 are both set. It falls only after a bus write.
- R8: With both step registers non-zero, each overflow adds the negative step to a signed accumulator. If the sum is negative, the positive step minus the negative step is also added, and the next counting tick after the overflow is skipped, so that period is one tick longer.
- R9: If either step register is zero, the accumulator holds its value and no period is lengthened.
- R10: A write to the count register clears the accumulator and cancels any pending skipped tick.
- R11: Reading the count register returns the current count and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Functional tick enable, one cycle per reference tick |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Overflow interrupt |

## Verification
Some properties are checked on every cycle. A stopped counter stays still unless the bus writes it. An overflow leaves the reload value in the count on the next cycle and always sets the flag. A stretch tick holds the count. A count write zeroes the accumulator. Idle step registers freeze the accumulator. The prescaler never emits two counting ticks back to back. The irq line falls only after a bus write.

Only the directed scenarios can show the rest. These are the exact divide ratios, and the prescaler restart on a control write. They also cover the write-1-to-clear semantics, and the period sequence 32, 33, 33, 33, 33, 32, ... that the accumulator yields. Finally, they show that rewriting the count restarts that sequence from the beginning.

// File: rtl/tt_pkg.sv
package tt_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd1;
   localparam logic [ADDR_W-1:0] A_IEN    = 3'd2;
   localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
   localparam logic [ADDR_W-1:0] A_RELOAD = 3'd4;
   localparam logic [ADDR_W-1:0] A_TRIG   = 3'd5;
   localparam logic [ADDR_W-1:0] A_INCP   = 3'd6;
   localparam logic [ADDR_W-1:0] A_INCN   = 3'd7;

   localparam int C_RUN = 0;
   localparam int C_AR  = 1;
   localparam int C_PRE = 2;
   localparam int C_SEL = 3;
   localparam int F_OVF = 1;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
   parameter int PSW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           enable,
   input  logic [PSW-1:0] sel,
   input  logic           restart,
   output logic           pulse
);
   localparam int PCW = 1 << PSW;
   localparam logic [PCW-1:0] ONES = '1;

   logic [PCW-1:0] pcnt_q;
   logic [PCW-1:0] term;

   assign term  = ONES >> (PCW - 1 - int'(sel));
   assign pulse = enable ? (tick && (pcnt_q == term)) : tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt_q <= '0;
      else if (restart)
         pcnt_q <= '0;
      else if (enable && tick)
         pcnt_q <= (pcnt_q == term) ? '0 : pcnt_q + 1'b1;
   end

   AST_PRESC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && pulse && !restart) |=> !pulse); // R3
endmodule

// File: rtl/tt_corrector.sv
module tt_corrector #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ovf,
   input  logic         clr,
   input  logic [W-1:0] inc_pos,
   input  logic [W-1:0] inc_neg,
   output logic         stretch
);
   logic [W-1:0] acc_q;
   logic [W-1:0] sum;
   logic [W-1:0] span;
   logic         active;

   assign active  = (|inc_pos) && (|inc_neg);
   assign sum     = acc_q + inc_neg;
   assign span    = inc_pos - inc_neg;
   assign stretch = ovf && active && sum[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clr)
         acc_q <= '0;
      else if (ovf && active)
         acc_q <= sum[W-1] ? sum + span : sum;
   end

   AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0)); // R10
   AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !clr) |=> $stable(acc_q)); // R9
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         trig,
   input  logic [W-1:0] reload_val,
   input  logic         reload_en,
   input  logic         stretch,
   output logic [W-1:0] count,
   output logic         ovf
);
   logic [W-1:0] cnt_q;
   logic         hold_q;

   assign count = cnt_q;
   assign ovf   = step && !hold_q && (&cnt_q) && !ld && !trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hold_q <= 1'b0;
      end else if (ld) begin
         cnt_q  <= ld_val;
         hold_q <= 1'b0;
      end else if (trig) begin
         cnt_q  <= reload_val;
         hold_q <= 1'b0;
      end else if (step) begin
         if (hold_q)
            hold_q <= 1'b0;
         else if (&cnt_q) begin
            cnt_q  <= reload_en ? reload_val : '0;
            hold_q <= stretch;
         end else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && step && !ld && !trig) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
   parameter int W       = 32,
   parameter int PSW     = 3,
   parameter bit CORR_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_en,
   input  logic [tt_pkg::ADDR_W-1:0] bus_addr,
   input  logic                  bus_we,
   input  logic [W-1:0]          bus_wdata,
   output logic [W-1:0]          bus_rdata,
   output logic                  irq
);
   import tt_pkg::*;

   if (W < 16) begin : g_bad_width
      $error("tick_timer: W must be at least 16");
   end
   if (PSW < 1 || PSW > 4) begin : g_bad_psw
      $error("tick_timer: PSW must be 1..4");
   end
   if (C_SEL + PSW > W) begin : g_bad_fit
      $error("tick_timer: control field exceeds data width");
   end

   logic           run_q, ar_q, pre_q, ovf_flag_q, ovf_ien_q;
   logic [PSW-1:0] sel_q;
   logic [W-1:0]   reload_q, incp_q, incn_q;

   logic wr_ctrl, wr_flags, wr_ien, wr_count, wr_reload, wr_trig, wr_incp, wr_incn;
   assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
   assign wr_flags  = bus_we && (bus_addr == A_FLAGS);
   assign wr_ien    = bus_we && (bus_addr == A_IEN);
   assign wr_count  = bus_we && (bus_addr == A_COUNT);
   assign wr_reload = bus_we && (bus_addr == A_RELOAD);
   assign wr_trig   = bus_we && (bus_addr == A_TRIG);
   assign wr_incp   = bus_we && (bus_addr == A_INCP);
   assign wr_incn   = bus_we && (bus_addr == A_INCN);

   logic         step, ovf, stretch;
   logic [W-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         ar_q     <= 1'b0;
         pre_q    <= 1'b0;
         sel_q    <= '0;
         ovf_ien_q <= 1'b0;
         reload_q <= '0;
         incp_q   <= '0;
         incn_q   <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q <= bus_wdata[C_RUN];
            ar_q  <= bus_wdata[C_AR];
            pre_q <= bus_wdata[C_PRE];
            sel_q <= bus_wdata[C_SEL +: PSW];
         end
         if (wr_ien)    ovf_ien_q <= bus_wdata[F_OVF];
         if (wr_reload) reload_q  <= bus_wdata;
         if (wr_incp)   incp_q    <= bus_wdata;
         if (wr_incn)   incn_q    <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf_flag_q <= 1'b0;
      else if (ovf)
         ovf_flag_q <= 1'b1;
      else if (wr_flags && bus_wdata[F_OVF])
         ovf_flag_q <= 1'b0;
   end

   assign irq = ovf_flag_q && ovf_ien_q;

   tt_prescaler #(.PSW(PSW)) u_presc (
      .clk(clk), .rst_n(rst_n), .tick(tick_en && run_q), .enable(pre_q),
      .sel(sel_q), .restart(wr_ctrl), .pulse(step)
   );

   tt_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .ld(wr_count), .ld_val(bus_wdata),
      .trig(wr_trig), .reload_val(reload_q), .reload_en(ar_q),
      .stretch(stretch), .count(count), .ovf(ovf)
   );

   if (CORR_EN) begin : g_corr
      tt_corrector #(.W(W)) u_corr (
         .clk(clk), .rst_n(rst_n), .ovf(ovf), .clr(wr_count),
         .inc_pos(incp_q), .inc_neg(incn_q), .stretch(stretch)
      );
   end else begin : g_nocorr
      assign stretch = 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL: begin
            bus_rdata[C_RUN]        = run_q;
            bus_rdata[C_AR]         = ar_q;
            bus_rdata[C_PRE]        = pre_q;
            bus_rdata[C_SEL +: PSW] = sel_q;
         end
         A_FLAGS:  bus_rdata[F_OVF] = ovf_flag_q;
         A_IEN:    bus_rdata[F_OVF] = ovf_ien_q;
         A_COUNT:  bus_rdata = count;
         A_RELOAD: bus_rdata = reload_q;
         A_INCP:   bus_rdata = incp_q;
         A_INCN:   bus_rdata = incn_q;
         default:  bus_rdata = '0;
      endcase
   end

   AST_FROZEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wr_count && !wr_trig) |=> $stable(count)); // R2
   AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && ar_q) |=> (count == $past(reload_q))); // R4
   AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf_flag_q); // R6
   AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_we)); // R7
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   tick_timer dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   localparam logic [31:0] NEG_STEP = 32'hFFF44800; // -768000
   localparam logic [31:0] BASE     = 32'hFFFFFFE0; // 32-tick period

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
   endtask

   task automatic period(output int n);
      n = 0;
      do begin
         ticks(1);
         n++;
      end while (!irq && n < 100);
      wr(3'd1, 32'h2);
   endtask

   // model of R8: returns lengths of successive periods from a cleared state
   task automatic run_model_check(string req, int count_p);
      int acc = 0;
      int sprev = 0;
      int got;
      for (int k = 0; k < count_p; k++) begin
         period(got);
         check(req, got, 32 + sprev);
         acc = acc - 768000;
         if (acc < 0) begin acc = acc + 1000000; sprev = 1; end
         else sprev = 0;
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(3'd3, v); check("R1 count", v, 0);
      rd(3'd0, v); check("R1 ctrl", v, 0);
      rd(3'd1, v); check("R1 flags", v, 0);
      rd(3'd4, v); check("R1 reload", v, 0);
      check("R1 irq", {31'b0, irq}, 0);
   endtask

   task automatic t_run_stop();
      logic [31:0] v;
      wr(3'd3, 32'd100);
      wr(3'd0, 32'h1);
      ticks(5);
      rd(3'd3, v); check("R3 bypass / R5 count write", v, 105);
      wr(3'd0, 32'h0);
      ticks(4);
      rd(3'd3, v); check("R2 stopped", v, 105);
      rd(3'd3, v); check("R11 reread", v, 105);
   endtask

   task automatic t_prescale();
      logic [31:0] v;
      wr(3'd3, 32'd0);
      wr(3'd0, 32'h15);          // run, prescale, S=2 -> /8
      ticks(24);
      rd(3'd3, v); check("R3 div8", v, 3);
      ticks(7);
      rd(3'd3, v); check("R3 div8 partial", v, 3);
      ticks(1);
      rd(3'd3, v); check("R3 div8 edge", v, 4);
      ticks(3);                  // partial count then restart
      wr(3'd0, 32'h05);          // S=0 -> /2, restart
      ticks(4);
      rd(3'd3, v); check("R3 div2 restart", v, 6);
      wr(3'd0, 32'h0);
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      wr(3'd4, 32'hFFFFFFF0);
      wr(3'd3, 32'hFFFFFFFE);
      wr(3'd0, 32'h3);
      ticks(1);
      rd(3'd1, v); check("R6 no flag yet", v, 0);
      ticks(1);
      rd(3'd3, v); check("R4 reload", v, 32'hFFFFFFF0);
      rd(3'd1, v); check("R6 flag set", v, 2);
      check("R7 irq masked", {31'b0, irq}, 0);
      wr(3'd2, 32'h2);
      #1 check("R7 irq enabled", {31'b0, irq}, 1);
      wr(3'd1, 32'h5);
      rd(3'd1, v); check("R6 other bits ignored", v, 2);
      wr(3'd1, 32'h2);
      rd(3'd1, v); check("R6 cleared", v, 0);
      check("R7 irq low", {31'b0, irq}, 0);
      wr(3'd0, 32'h1);           // no auto-reload
      wr(3'd3, 32'hFFFFFFFF);
      ticks(1);
      rd(3'd3, v); check("R4 wrap", v, 0);
      rd(3'd1, v); check("R6 wrap flag", v, 2);
      wr(3'd1, 32'h2);
      wr(3'd0, 32'h0);
   endtask

   task automatic t_trigger();
      logic [31:0] v;
      wr(3'd4, 32'h1234);
      wr(3'd5, 32'h0);
      rd(3'd3, v); check("R5 trigger", v, 32'h1234);
   endtask

   task automatic t_correction();
      wr(3'd6, 32'd232000);
      wr(3'd7, NEG_STEP);
      wr(3'd4, BASE);
      wr(3'd3, BASE);
      wr(3'd2, 32'h2);
      wr(3'd0, 32'h3);
      run_model_check("R8 period", 8);
      wr(3'd3, BASE);             // clears accumulator
      run_model_check("R10 restart", 6);
      wr(3'd6, 32'd0);
      wr(3'd3, BASE);
      for (int k = 0; k < 4; k++) begin
         int got;
         period(got);
         check("R9 inactive", got, 32);
      end
      wr(3'd0, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_run_stop();
      t_prescale();
      t_overflow();
      t_trigger();
      t_correction();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule